// File: doc/BRIEF.md
# Memory Self-Test Sequencer for a Single-Port RAM

This block sits in front of a single-port synchronous RAM and can take the RAM over for a self-test. While `test_mode` is low, the functional address, write data and write enable pass straight through to the RAM. While `test_mode` is high, the RAM inputs come from the block's own generators. When the block is idle in test mode, the write enable is held low.

A `start` pulse in test mode launches a fixed sweep. An address counter walks the whole address range. A data generator supplies three backgrounds in turn: zeros, then ones, then alternating bits. For each background the block first writes every address, then reads every address back. A comparator checks each read word one cycle after the read is issued. The block raises `done` at the end of the sweep. It reports a sticky `fail` flag and holds the address of the first word that read back wrong.

The sequencer has five states:

| State | Role |
|---|---|
| IDLE | Waiting for a start. |
| WRITE | Writing the current background. |
| READ | Reading back and checking. |
| FLUSH | One cycle that lets the final compare finish. |
| DONE | Results held. |

The transitions are:

| From | Condition | To |
|---|---|---|
| IDLE or DONE | `start` with `test_mode` high | WRITE |
| WRITE | last address | READ |
| READ | last address, more backgrounds remain | WRITE |
| READ | last address, last background | FLUSH |
| FLUSH | always | DONE |
| any state | `test_mode` low | IDLE |

Top module: `mbist_ctrl`

## Requirements
- R1: After reset, `busy`, `done` and `fail` are 0 and `fail_addr` is 0.
- R2: While `test_mode` is 0, `ram_addr`, `ram_wdata` and `ram_we` equal `func_addr`, `func_wdata` and `func_we` in the same cycle.
- R3: While `test_mode` is 1 and no sweep is running, `ram_we` is 0 regardless of `func_we`.
- R4: On the edge that accepts `start`, the sweep begins. It then drives 6·DEPTH cycles in six stages of DEPTH cycles each, where DEPTH = 2^ADDR_W. The stages run write, read, write, read, write, read. Within each stage, addresses run 0 to DEPTH-1 in ascending order. `ram_we` is 1 exactly in the write stages.
- R5: The backgrounds used in stages 1–2, 3–4 and 5–6 are all zeros, all ones, and alternating bits with bit 0 equal to 1 (0x55 for 8 bits). `ram_wdata` carries the current background throughout the test.
- R6: `busy` stays 1 for the 6·DEPTH sweep cycles plus one flush cycle. On the next cycle `done` is 1 and `busy` is 0. `done` holds until `test_mode` falls or a new start is accepted.
- R7: With a fault-free RAM of one-cycle read latency, `fail` is 0 when `done` rises.
- R8: When a read word differs from the background, `fail` is 1 at `done`. `fail_addr` holds the address of the first such word in sweep order, taken over backgrounds and then addresses.
- R9: Once `fail` is set, it and `fail_addr` keep their values until a new start is accepted, even if later reads also mismatch.
- R10: A `start` pulse during a running sweep is ignored. Dropping `test_mode` during a sweep returns the block to IDLE, with `busy` and `done` both 0.
- R11: An accepted start clears `fail` and `fail_addr`, so a clean re-run reports no failure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_mode | input | 1 | Selects self-test control of the RAM |
| start | input | 1 | Launches a sweep when high in test mode |
| func_addr | input | ADDR_W | Functional address |
| func_wdata | input | DATA_W | Functional write data |
| func_we | input | 1 | Functional write enable |
| ram_rdata | input | DATA_W | RAM read data, one cycle after the address |
| ram_addr | output | ADDR_W | RAM address |
| ram_wdata | output | DATA_W | RAM write data |
| ram_we | output | 1 | RAM write enable |
| busy | output | 1 | Sweep in progress (write, read or flush) |
| done | output | 1 | Sweep complete, results valid |
| fail | output | 1 | Sticky miscompare flag |
| fail_addr | output | ADDR_W | Address of the first miscompare |

## Verification
A wrong state or background register shows up at once on `ram_we`, `ram_addr` or `ram_wdata`. The bench compares all three against the expected sweep in every cycle, so such a fault is caught within one cycle of its first effect. A fault in the comparator's delay stage or its first-failure capture shows up only at `done`, as a wrong `fail` or `fail_addr`. Faults are therefore placed so that the first failure in sweep order differs from the lowest failing address, and one fault sits on the last address of a stage.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_READ,
        ST_FLUSH,
        ST_DONE
    } bist_state_t;

    typedef enum logic [1:0] {
        BG_ZERO,
        BG_ONE,
        BG_ALT
    } bist_bg_t;

endpackage

// File: rtl/mbist_addr_ctr.sv
module mbist_addr_ctr #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              inc,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    localparam logic [ADDR_W-1:0] TOP = {ADDR_W{1'b1}};

    logic [ADDR_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;      // wraps to zero after the top address
        end
    end

    assign addr = cnt_q;
    assign last = (cnt_q == TOP);
endmodule

// File: rtl/mbist_pattern.sv
module mbist_pattern
    import mbist_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  bist_bg_t          bg,
    output logic [DATA_W-1:0] pattern
);
    logic [DATA_W-1:0] alt;

    // even bit positions carry 1, odd positions carry 0
    for (genvar i = 0; i < DATA_W; i++) begin : g_alt
        assign alt[i] = ((i % 2) == 0) ? 1'b1 : 1'b0;
    end

    always_comb begin
        unique case (bg)
            BG_ZERO: pattern = '0;
            BG_ONE:  pattern = '1;
            BG_ALT:  pattern = alt;
            default: pattern = '0;
        endcase
    end
endmodule

// File: rtl/mbist_compare.sv
module mbist_compare #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              sample,
    input  logic [DATA_W-1:0] exp_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] rdata,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr
);
    logic              vld_q;
    logic [DATA_W-1:0] exp_q;
    logic [ADDR_W-1:0] addr_q;
    logic              miss;

    // the expected word and its address travel one cycle behind the read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            exp_q  <= '0;
            addr_q <= '0;
        end else if (clr) begin
            vld_q  <= 1'b0;
        end else begin
            vld_q  <= sample;
            exp_q  <= exp_in;
            addr_q <= addr_in;
        end
    end

    assign miss = vld_q && (rdata != exp_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fail      <= 1'b0;
            fail_addr <= '0;
        end else if (clr) begin
            fail      <= 1'b0;
            fail_addr <= '0;
        end else if (miss && !fail) begin
            fail      <= 1'b1;
            fail_addr <= addr_q;
        end
    end
endmodule

// File: rtl/mbist_ctrl.sv
module mbist_ctrl
    import mbist_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              test_mode,
    input  logic              start,
    input  logic [ADDR_W-1:0] func_addr,
    input  logic [DATA_W-1:0] func_wdata,
    input  logic              func_we,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    output logic              ram_we,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr
);
    bist_state_t       state_q, state_d;
    bist_bg_t          bg_q;
    logic [ADDR_W-1:0] t_addr;
    logic [DATA_W-1:0] t_data;
    logic              t_we;
    logic              addr_last;
    logic              go;
    logic              step;
    logic              bg_adv;
    logic              rd_issue;

    assign go = test_mode && start && (state_q == ST_IDLE || state_q == ST_DONE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (go) state_d = ST_WRITE;
            ST_WRITE: begin
                if (!test_mode)     state_d = ST_IDLE;
                else if (addr_last) state_d = ST_READ;
            end
            ST_READ: begin
                if (!test_mode)     state_d = ST_IDLE;
                else if (addr_last) state_d = (bg_q == BG_ALT) ? ST_FLUSH : ST_WRITE;
            end
            ST_FLUSH: state_d = test_mode ? ST_DONE : ST_IDLE;
            ST_DONE: begin
                if (!test_mode) state_d = ST_IDLE;
                else if (go)    state_d = ST_WRITE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs of the sequencer
    always_comb begin
        t_we     = 1'b0;
        step     = 1'b0;
        rd_issue = 1'b0;
        busy     = 1'b0;
        done     = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_WRITE: begin
                t_we = 1'b1;
                step = 1'b1;
                busy = 1'b1;
            end
            ST_READ: begin
                step     = 1'b1;
                rd_issue = test_mode;
                busy     = 1'b1;
            end
            ST_FLUSH: busy = 1'b1;
            ST_DONE:  done = 1'b1;
            default:  ;
        endcase
    end

    assign bg_adv = (state_q == ST_READ) && test_mode && addr_last && (bg_q != BG_ALT);

    // background register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bg_q <= BG_ZERO;
        end else if (go) begin
            bg_q <= BG_ZERO;
        end else if (bg_adv) begin
            bg_q <= (bg_q == BG_ZERO) ? BG_ONE : BG_ALT;
        end
    end

    mbist_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (go),
        .inc   (step && test_mode),
        .addr  (t_addr),
        .last  (addr_last)
    );

    mbist_pattern #(.DATA_W(DATA_W)) u_pat (
        .bg      (bg_q),
        .pattern (t_data)
    );

    mbist_compare #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (go),
        .sample    (rd_issue),
        .exp_in    (t_data),
        .addr_in   (t_addr),
        .rdata     (ram_rdata),
        .fail      (fail),
        .fail_addr (fail_addr)
    );

    // RAM input multiplexers
    always_comb begin
        if (test_mode) begin
            ram_addr  = t_addr;
            ram_wdata = t_data;
            ram_we    = t_we;
        end else begin
            ram_addr  = func_addr;
            ram_wdata = func_wdata;
            ram_we    = func_we;
        end
    end
endmodule

// File: rtl/mbist_ctrl_chk.sv
module mbist_ctrl_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              test_mode,
    input logic              start,
    input logic              ram_we,
    input logic [ADDR_W-1:0] ram_addr,
    input logic              busy,
    input logic              done,
    input logic              fail,
    input logic [ADDR_W-1:0] fail_addr
);
    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (test_mode && !busy) |-> !ram_we); // R3

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && test_mode) |=> (!busy || !test_mode ||
                                 ram_addr == ADDR_W'($past(ram_addr) + 1'b1))); // R4

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy)); // R6

    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !start) |=> fail); // R9

    AST_FAIL_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !start) |=> $stable(fail_addr)); // R9
endmodule

bind mbist_ctrl mbist_ctrl_chk #(.ADDR_W(ADDR_W)) u_mbist_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .test_mode (test_mode),
    .start     (start),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .busy      (busy),
    .done      (done),
    .fail      (fail),
    .fail_addr (fail_addr)
);

// File: tb/test_mbist_ctrl.sv
`timescale 1ns/1ps
module test_mbist_ctrl;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int D  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          test_mode = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] func_addr = '0;
    logic [DW-1:0] func_wdata = '0;
    logic          func_we = 1'b0;
    logic [DW-1:0] ram_rdata;
    logic [AW-1:0] ram_addr;
    logic [DW-1:0] ram_wdata;
    logic          ram_we;
    logic          busy, done, fail;
    logic [AW-1:0] fail_addr;

    int checks = 0;
    int errors = 0;

    logic [DW-1:0] mem [D];
    logic [DW-1:0] sa0 [D];
    logic [DW-1:0] sa1 [D];

    always #5 clk = ~clk;

    mbist_ctrl #(.ADDR_W(AW), .DATA_W(DW)) i_mbist_ctrl (
        .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .start(start),
        .func_addr(func_addr), .func_wdata(func_wdata), .func_we(func_we),
        .ram_rdata(ram_rdata), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .ram_we(ram_we), .busy(busy), .done(done), .fail(fail), .fail_addr(fail_addr)
    );

    // behavioural RAM, one-cycle read latency, per-address stuck bits
    always @(posedge clk) begin
        if (ram_we) mem[ram_addr] <= ram_wdata;
        ram_rdata <= (mem[ram_addr] & ~sa0[ram_addr]) | sa1[ram_addr];
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] bg_val(input int b);
        logic [DW-1:0] v;
        for (int i = 0; i < DW; i++) v[i] = (b == 0) ? 1'b0 : (b == 1) ? 1'b1 : ((i % 2) == 0);
        return v;
    endfunction

    // first failing address in sweep order; -1 if none
    function automatic int first_fail();
        for (int b = 0; b < 3; b++)
            for (int a = 0; a < D; a++)
                if (((bg_val(b) & ~sa0[a]) | sa1[a]) != bg_val(b)) return a;
        return -1;
    endfunction

    task automatic clear_faults();
        for (int a = 0; a < D; a++) begin sa0[a] = '0; sa1[a] = '0; end
    endtask

    // full sweep with per-cycle port checks; optional stray start mid-run
    task automatic run_sweep(input string tag, input bit stray);
        int exp_fa;
        int sweep_err;
        exp_fa = first_fail();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        sweep_err = 0;
        for (int k = 0; k < 6*D; k++) begin
            int stage;
            stage = k / D;
            if ((ram_addr !== AW'(k % D)) || (ram_we !== ((stage % 2) == 0)) ||
                (ram_wdata !== bg_val(stage / 2)) || (busy !== 1'b1)) begin
                sweep_err++;
                $display("FAIL R4/R5 %s k=%0d actual addr=%0h we=%0b data=%0h expected addr=%0h we=%0b data=%0h",
                         tag, k, ram_addr, ram_we, ram_wdata, k % D, (stage % 2) == 0, bg_val(stage / 2));
            end
            if (stray && k == D + 3) start = 1'b1;   // R10: ignored while running
            @(negedge clk);
            start = 1'b0;
        end
        checks++;
        if (sweep_err != 0) errors++;
        chk({"R6 flush busy ", tag}, busy, 1'b1);
        chk({"R6 flush done ", tag}, done, 1'b0);
        @(negedge clk);
        chk({"R6 done ", tag}, done, 1'b1);
        chk({"R6 busy low ", tag}, busy, 1'b0);
        chk({"R7/R8 fail ", tag}, fail, exp_fa >= 0);
        if (exp_fa >= 0) chk({"R8 fail_addr ", tag}, fail_addr, exp_fa);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        clear_faults();
        for (int a = 0; a < D; a++) mem[a] = '0;
        repeat (3) @(negedge clk);
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 fail", fail, 0);
        chk("R1 fail_addr", fail_addr, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 pass-through patterns
        for (int p = 0; p < 4; p++) begin
            func_addr = AW'(p * 5 + 1); func_wdata = DW'(8'h3c ^ (p * 37)); func_we = p[0];
            #1;
            chk("R2 addr", ram_addr, func_addr);
            chk("R2 wdata", ram_wdata, func_wdata);
            chk("R2 we", ram_we, func_we);
            @(negedge clk);
        end

        // R3 idle in test mode blocks writes
        test_mode = 1'b1; func_we = 1'b1;
        #1 chk("R3 we blocked", ram_we, 0);
        @(negedge clk);
        func_we = 1'b0;

        run_sweep("clean R7", 1'b0);
        sa1[5] = 8'h08;                          // fails in zeros background
        run_sweep("sa1 R8", 1'b0);
        chk("R9 held in DONE", fail_addr, 5);
        clear_faults(); sa0[9] = 8'h80;          // fails in ones background
        run_sweep("sa0 R8", 1'b0);
        clear_faults(); sa0[2] = 8'h01; sa1[11] = 8'h40;  // time order beats address order
        run_sweep("order R9", 1'b0);
        clear_faults(); sa0[D-1] = 8'h01;        // last address of a read stage
        run_sweep("last addr R8", 1'b0);
        clear_faults();
        run_sweep("rerun R11", 1'b1);            // also stray start R10

        // R10 abort by dropping test mode
        start = 1'b1; @(negedge clk); start = 1'b0;
        repeat (D + 2) @(negedge clk);
        chk("R10 running", busy, 1);
        test_mode = 1'b0; func_addr = 4'h7; func_we = 1'b1;
        #1 chk("R10 R2 handover", ram_addr, 4'h7);
        @(negedge clk);
        chk("R10 abort busy", busy, 0);
        chk("R10 abort done", done, 0);
        func_we = 1'b0; test_mode = 1'b1;
        #1 chk("R3 after abort", ram_we, 0);
        @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule